// File: doc/BRIEF.md
# Key-Release Filter and Scan-Code to ASCII Translator

This block sits behind a keyboard code receiver that delivers 7-bit scan codes, with the top bit of each keyboard byte already dropped. It passes on only key presses, as 8-bit ASCII characters. The release prefix 0x70 is the 0xF0 release byte with its top bit gone. When that prefix arrives, the block drops the prefix and also drops the next non-zero code, which names the key that was let go. Every other non-zero code is used directly as the address into a 128-entry character table. That table is filled through a plain write port.

Codes arrive on a valid/ready stream. A code moves when `code_valid` and `code_ready` are both high at a rising clock edge. Characters leave on a second valid/ready stream. A character moves when `chr_valid` and `chr_ready` are both high at a rising edge. While a character waits for the sink, `code_ready` stays low, so back-pressure on the output reaches the input directly. The block gives the receiver a one-cycle `rcv_clear` pulse for every non-zero code it consumes, whether that code is translated or dropped.

Multi-byte extended sequences are handled as ordinary codes.

Top module: `kbd_ascii_xlate`

## Requirements
- R1: After reset, `chr_valid` and `rcv_clear` are low and `code_ready` is high. Every table entry reads as zero, so no code yields a character until the table is written.
- R2: A non-zero code other than 0x70, accepted while idle, whose table entry is non-zero, gives exactly one character equal to that entry. `chr_valid` rises in the cycle after the accepting edge.
- R3: While `chr_valid` is high and `chr_ready` is low, `chr_valid` stays high and `chr` holds its value. During that time `code_ready` is low.
- R4: An accepted code of zero has no effect. No character is produced, no clear pulse is sent, and the release-waiting state is left as it was.
- R5: The code 0x70 accepted while idle produces no character. The next accepted non-zero code is dropped without output, and the block then returns to idle.
- R6: Zero codes that arrive while the block waits for the released-key code do not end the wait.
- R7: A second 0x70 that arrives while waiting is itself the dropped code. The code after it is translated normally.
- R8: A code whose table entry is zero is consumed without output, and it still produces a clear pulse.
- R9: `rcv_clear` goes high for exactly one cycle, the cycle after each accepted non-zero code. This holds for translated codes, dropped codes and prefixes alike.
- R10: With `tbl_we` high, `tbl_data` is stored at `tbl_addr` on the clock edge. A code accepted on that same edge is looked up with the entry as it was before the write.
- R11: 0x70 always acts as the release prefix, even when its table entry is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_valid | input | 1 | Scan code on `code` is offered |
| code_ready | output | 1 | Block can take a code (low while a character is pending) |
| code | input | 7 | Scan code from the receiver |
| chr_valid | output | 1 | Character on `chr` is offered |
| chr_ready | input | 1 | Sink takes the character |
| chr | output | 8 | ASCII character |
| rcv_clear | output | 1 | One-cycle clear pulse to the receiver |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 7 | Table write address |
| tbl_data | input | 8 | Table write data |

## Verification
The case most likely to go wrong is a table write and a lookup that hit the same entry on the same edge. The bench raises `tbl_we` together with `code_valid` for a single code whose entry is being rewritten. The scoreboard expects the old character for that code and the new character for the next time the same code is sent. A second overlap occurs when the clear pulse and the start of an emitted character fall in the same cycle. The bench counts those clear pulses separately from the characters, so an overlap can neither hide a pulse nor duplicate one.

// File: rtl/kx_pkg.sv
package kx_pkg;
  typedef enum logic [1:0] {
    KX_IDLE  = 2'd0,
    KX_AWAIT = 2'd1,
    KX_EMIT  = 2'd2
  } kx_state_e;
endpackage

// File: rtl/kx_table.sv
module kx_table #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (we && (waddr == AW'(i)))
        mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // a write lands exactly where it was aimed
  assert_wr_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/kx_filter.sv
module kx_filter
  import kx_pkg::*;
#(
  parameter int             CW        = 7,
  parameter int             DW        = 8,
  parameter logic [CW-1:0]  BRK_CODE  = 7'h70
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          code_valid,
  output logic          code_ready,
  input  logic [CW-1:0] code,
  input  logic [DW-1:0] entry,
  output logic          chr_valid,
  input  logic          chr_ready,
  output logic [DW-1:0] chr,
  output logic          clear
);
  kx_state_e     state, state_nx;
  logic [DW-1:0] chr_q;
  logic          clear_q;
  logic          take, nonzero, is_brk, mapped;

  assign take    = code_valid && code_ready;
  assign nonzero = (code != '0);
  assign is_brk  = (code == BRK_CODE);
  assign mapped  = (entry != '0);

  always_comb begin
    state_nx = state;
    case (state)
      KX_IDLE:
        if (take && nonzero) begin
          if (is_brk)      state_nx = KX_AWAIT;
          else if (mapped) state_nx = KX_EMIT;
        end
      KX_AWAIT:
        if (take && nonzero) state_nx = KX_IDLE;
      KX_EMIT:
        if (chr_ready) state_nx = KX_IDLE;
      default: state_nx = KX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= KX_IDLE;
      chr_q   <= '0;
      clear_q <= 1'b0;
    end else begin
      state   <= state_nx;
      clear_q <= take && nonzero;
      if (state == KX_IDLE && take && nonzero && !is_brk)
        chr_q <= entry;
    end
  end

  assign code_ready = (state != KX_EMIT);
  assign chr_valid  = (state == KX_EMIT);
  assign chr        = chr_q;
  assign clear      = clear_q;

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid && !chr_ready |=> chr_valid && $stable(chr));

  assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid |-> !code_ready);

  assert_char_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid |-> chr != '0);

  assert_zero_noop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take && !nonzero |=> $stable(state) && !clear);

  assert_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state == KX_AWAIT && take && nonzero |=> state == KX_IDLE && clear && !chr_valid);

  assert_clear_with_char_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chr_valid) |-> clear);

  assert_prefix_R11: assert property (@(posedge clk) disable iff (!rst_n)
    state == KX_IDLE && take && is_brk |=> state == KX_AWAIT);
endmodule

// File: rtl/kbd_ascii_xlate.sv
module kbd_ascii_xlate #(
  parameter int            CODE_W   = 7,
  parameter int            CHR_W    = 8,
  parameter logic [CODE_W-1:0] BRK_CODE = 7'h70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_valid,
  output logic              code_ready,
  input  logic [CODE_W-1:0] code,
  output logic              chr_valid,
  input  logic              chr_ready,
  output logic [CHR_W-1:0]  chr,
  output logic              rcv_clear,
  input  logic              tbl_we,
  input  logic [CODE_W-1:0] tbl_addr,
  input  logic [CHR_W-1:0]  tbl_data
);
  logic [CHR_W-1:0] entry;

  kx_table #(.AW(CODE_W), .DW(CHR_W)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_data),
    .raddr (code),
    .rdata (entry)
  );

  kx_filter #(.CW(CODE_W), .DW(CHR_W), .BRK_CODE(BRK_CODE)) u_filter (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_valid (code_valid),
    .code_ready (code_ready),
    .code       (code),
    .entry      (entry),
    .chr_valid  (chr_valid),
    .chr_ready  (chr_ready),
    .chr        (chr),
    .clear      (rcv_clear)
  );

  assert_clear_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid && code_ready && code != '0 |=> rcv_clear);
endmodule

// File: tb/kbd_ascii_xlate_tb.sv
module kbd_ascii_xlate_tb;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       code_valid = 1'b0;
  logic       code_ready;
  logic [6:0] code = '0;
  logic       chr_valid;
  logic       chr_ready;
  logic [7:0] chr;
  logic       rcv_clear;
  logic       tbl_we = 1'b0;
  logic [6:0] tbl_addr = '0;
  logic [7:0] tbl_data = '0;
  logic       bp = 1'b0;

  int checks = 0, fails = 0;
  int exp_clr = 0, obs_clr = 0;
  logic [7:0] exp_q[$];
  logic [7:0] tbl_m [128];
  bit awaiting = 0;

  always #(PERIOD/2) clk = ~clk;
  assign chr_ready = !bp;

  kbd_ascii_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_ready(code_ready),
    .code(code), .chr_valid(chr_valid), .chr_ready(chr_ready), .chr(chr),
    .rcv_clear(rcv_clear), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model of the requirements, run at drive time
  task automatic model(input logic [6:0] c, input logic [7:0] ent);
    if (c == 0) return;
    exp_clr++;
    if (awaiting) awaiting = 0;
    else if (c == 7'h70) awaiting = 1;
    else if (ent != 0) exp_q.push_back(ent);
  endtask

  task automatic send(input logic [6:0] c);
    model(c, tbl_m[c]);
    code_valid = 1'b1;
    code = c;
    while (!code_ready) @(negedge clk);
    @(negedge clk);
    code_valid = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    tbl_we = 1'b1; tbl_addr = a; tbl_data = d;
    @(negedge clk);
    tbl_we = 1'b0;
    tbl_m[a] = d;
  endtask

  task automatic settle(input string req);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    check(obs_clr == exp_clr, req, obs_clr, exp_clr);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rcv_clear) obs_clr++;
      if (chr_valid && chr_ready) begin
        if (exp_q.size() == 0) check(0, "R2 unexpected char", chr, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(chr == e, "R2 char", chr, e);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 150000);
    check(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) tbl_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(chr_valid == 0, "R1 chr_valid", chr_valid, 0);
    check(rcv_clear == 0, "R1 rcv_clear", rcv_clear, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(code_ready == 1, "R1 code_ready", code_ready, 1);
    send(7'h1C); send(7'h15);
    settle("R1 empty table");

    for (int i = 16; i < 64; i++) wr(7'(i), 8'(i + 32));
    send(7'h15); send(7'h1C); send(7'h2A); send(7'h3F);
    settle("R2");

    send(7'h00); send(7'h00);
    settle("R4");

    send(7'h05); send(7'h7F);
    settle("R8 unmapped");

    send(7'h70); send(7'h1C);
    settle("R5 discard");
    send(7'h15);
    settle("R5 resume");

    send(7'h70); send(7'h00); send(7'h00); send(7'h1C);
    settle("R6");

    send(7'h70); send(7'h70); send(7'h15);
    settle("R7");

    wr(7'h70, 8'h41);
    send(7'h70); send(7'h20);
    settle("R11");

    bp = 1'b1;
    send(7'h21);
    @(negedge clk);
    begin
      logic [7:0] held;
      held = chr;
      repeat (3) @(negedge clk);
      check(chr_valid == 1, "R3 valid held", chr_valid, 1);
      check(chr == held, "R3 chr stable", chr, held);
      check(code_ready == 0, "R3 input stalled", code_ready, 0);
    end
    bp = 1'b0;
    settle("R3");

    // write and lookup of the same entry on one edge
    model(7'h16, tbl_m[7'h16]);
    tbl_we = 1'b1; tbl_addr = 7'h16; tbl_data = 8'h7E;
    code_valid = 1'b1; code = 7'h16;
    @(negedge clk);
    tbl_we = 1'b0; code_valid = 1'b0;
    tbl_m[7'h16] = 8'h7E;
    settle("R10 old value");
    send(7'h16);
    settle("R10 new value");

    // back-to-back unmapped codes: one clear cycle each
    send(7'h01); send(7'h02); send(7'h03);
    settle("R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule